// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

This block is an 8-bit timer/counter that advances either once per internal instruction cycle or on edges of an external clock pin. The instruction cycle is four oscillator clocks long, and the block numbers those clocks as phases Q1 to Q4. One 8-bit prescaler serves two clients and is owned by only one of them at a time. It can sit in front of the timer and divide the timer's source. It can instead sit after the watchdog and divide the watchdog's raw timeout ticks. The client that does not own it runs undivided.

The external pin first passes through an input register. The edge-select option sets its polarity. Without the prescaler, the pin is sampled at the end of phases Q2 and Q4 and the timer steps at the end of Q4. With the prescaler, edges of the pin are counted at the full oscillator rate, and the selected prescaler bit is sampled on the same two phases. The overflow flag is sticky and software clears it. The watchdog counter, reset generation, CPU and interrupt controller are outside this block. There is no data stream in or out, so every pin is a plain control or status signal without a handshake.

Top module: `tmr_presc_unit`

## Requirements
- R1: Reset clears the timer to 0x00, the overflow flag to 0 and the prescaler count to 0.
- R2: With the instruction clock as source and the prescaler owned by the watchdog, the timer rises by exactly one at the end of every Q4. That is one count per 4 oscillator clocks, and two increments are never closer than 2 clocks apart.
- R3: With the prescaler owned by the timer (`opt_pre_to_wdt`=0), ratio code n divides the timer source by 2^(n+1), from 1:2 to 1:256. In this mode `wdt_tick` equals `wdt_raw_tick`.
- R4: With the prescaler owned by the watchdog (`opt_pre_to_wdt`=1), ratio code n passes one `wdt_tick` for every 2^n raw ticks, from 1:1 to 1:128. The pulse comes on the raw tick that completes a group. `wdt_tick` is never high while `wdt_raw_tick` is low.
- R5: With the pin as source (`opt_src_pin`=1) and no prescaler, the timer counts rising pin edges when `opt_edge_fall`=0 and falling edges when it is 1. Opposite edges do not count. Every pulse at least 2 clocks high and 2 clocks low is counted.
- R6: With the pin as source and the prescaler owned by the timer, pin edges are counted at the oscillator rate before sampling. At ratio 1:2, pulses 1 clock high and 1 clock low give one count per two pulses.
- R7: A write (`tmr_wr_en`) loads `tmr_wr_data` at the next clock edge. It overrides any increment in that cycle and discards a sampled edge that has not yet been counted. While the timer owns the prescaler, the write also clears the prescaler count.
- R8: `wdt_clr` clears the prescaler count only while the watchdog owns it. A timer write does not touch the count in that mode, and `wdt_clr` does not touch it while the timer owns it.
- R9: `tmr_ovf` sets when an increment takes the timer from 0xFF to 0x00. It stays set until `ovf_clr`, and a set in the same cycle beats the clear. Loading 0xFF by a write does not set it.
- R10: With the pin as source and no prescaler, the timer shows the increment 2 to 5 clocks after the clock edge at which a counted pin edge is first present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| ext_clk_pin | input | 1 | External count pin |
| tmr_wr_en | input | 1 | Timer write strobe |
| tmr_wr_data | input | 8 | Value to load into the timer |
| ovf_clr | input | 1 | Clears the overflow flag |
| wdt_raw_tick | input | 1 | Undivided timeout tick from the watchdog |
| wdt_clr | input | 1 | Watchdog clear command |
| opt_src_pin | input | 1 | 1: count the pin, 0: count instruction cycles |
| opt_edge_fall | input | 1 | 1: count falling pin edges, 0: rising |
| opt_pre_to_wdt | input | 1 | 1: prescaler owned by the watchdog, 0: by the timer |
| opt_ratio | input | 3 | Prescale ratio code |
| tmr_value | output | 8 | Current timer value |
| tmr_ovf | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Tick sent on to the watchdog counter |

## Verification
The assertions check on every clock edge that a write loads its data and that, without a write, the timer holds or steps by one. They also check that increments are at least two clocks apart, that the overflow flag sets on a wrap and then stays set, and that `wdt_tick` relates to `wdt_raw_tick` as the ownership bit requires. Some behaviours can only be shown by the directed scenarios, because they depend on history across many cycles. These are the division ratios in both directions, the edge polarity, clearing by a write against clearing by `wdt_clr`, the count of narrow pulses, and the 2-to-5-clock latency from pin edge to count.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int TMR_W  = 8;
  localparam int PRE_W  = 8;
  localparam int SEL_W  = 3;
  localparam int PH_W   = 2;

  typedef logic [PH_W-1:0] phase_t;
  localparam phase_t PH_Q2 = 2'd1;
  localparam phase_t PH_Q4 = 2'd3;

  typedef enum logic {SRC_INSTR = 1'b0, SRC_PIN = 1'b1} src_e;
  typedef enum logic {OWN_TMR = 1'b0, OWN_WDT = 1'b1} owner_e;
endpackage

// File: rtl/tps_phase_gen.sv
module tps_phase_gen
  import tps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic q2_end,
  output logic q4_end
);
  phase_t ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_q + phase_t'(1);
  end

  // Strobes are high during the last oscillator clock of a phase
  assign q2_end = (ph_q == PH_Q2);
  assign q4_end = (ph_q == PH_Q4);
endmodule

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_bit,
  output logic             grp_last
);
  localparam int TAPS = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] grp_mask;
  logic [TAPS-1:0]  taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + CNT_W'(1);
  end

  // Timer direction: bit n toggles every 2^n inputs, period 2^(n+1)
  genvar gi;
  generate
    for (gi = 0; gi < TAPS; gi++) begin : g_tap
      if (gi < CNT_W) begin : g_bit
        assign taps[gi] = cnt_q[gi];
      end else begin : g_pad
        assign taps[gi] = 1'b0;
      end
    end
  endgenerate
  assign tap_bit = taps[sel];

  // Watchdog direction: the input that completes a group of 2^n
  always_comb begin
    grp_mask = (CNT_W'(1) << sel) - CNT_W'(1);
    grp_last = ((cnt_q & grp_mask) == grp_mask);
  end
endmodule

// File: rtl/tps_edge_sync.sv
module tps_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic q2_end,
  input  logic q4_end,
  input  logic din,
  input  logic flush,
  output logic step
);
  logic smp_q;
  logic pend_q;
  logic rise;

  assign rise = (q2_end | q4_end) & din & ~smp_q;
  assign step = q4_end & (pend_q | rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (q2_end | q4_end) smp_q <= din;
      if (flush)           pend_q <= 1'b0;
      else if (q4_end)     pend_q <= 1'b0;
      else if (rise)       pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_presc_unit.sv
module tmr_presc_unit
  import tps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_pin,
  input  logic             tmr_wr_en,
  input  logic [TMR_W-1:0] tmr_wr_data,
  input  logic             ovf_clr,
  input  logic             wdt_raw_tick,
  input  logic             wdt_clr,
  input  logic             opt_src_pin,
  input  logic             opt_edge_fall,
  input  logic             opt_pre_to_wdt,
  input  logic [SEL_W-1:0] opt_ratio,
  output logic [TMR_W-1:0] tmr_value,
  output logic             tmr_ovf,
  output logic             wdt_tick
);
  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  src_e   src;
  owner_e owner;
  logic   q2_end, q4_end;
  logic   pin_s_q, pin_s2_q, pin_rise;
  logic   pre_en, pre_clr, pre_tap, pre_last;
  logic   sync_din, sync_step, use_sync;
  logic   inc;
  logic [TMR_W-1:0] tmr_q;
  logic   ovf_q;

  assign src   = src_e'(opt_src_pin);
  assign owner = owner_e'(opt_pre_to_wdt);

  tps_phase_gen u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .q2_end (q2_end),
    .q4_end (q4_end)
  );

  // Pin register with polarity applied; counted edges are rising afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s_q  <= 1'b0;
      pin_s2_q <= 1'b0;
    end else begin
      pin_s_q  <= ext_clk_pin ^ opt_edge_fall;
      pin_s2_q <= pin_s_q;
    end
  end
  assign pin_rise = pin_s_q & ~pin_s2_q;

  always_comb begin
    if (owner == OWN_WDT) begin
      pre_en  = wdt_raw_tick;
      pre_clr = wdt_clr;
    end else begin
      pre_en  = (src == SRC_PIN) ? pin_rise : q4_end;
      pre_clr = tmr_wr_en;
    end
  end

  tps_prescaler #(.CNT_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (pre_en),
    .clr      (pre_clr),
    .sel      (opt_ratio),
    .tap_bit  (pre_tap),
    .grp_last (pre_last)
  );

  assign sync_din = (owner == OWN_WDT) ? pin_s_q : pre_tap;
  assign use_sync = (src == SRC_PIN) | (owner == OWN_TMR);

  tps_edge_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .q2_end (q2_end),
    .q4_end (q4_end),
    .din    (sync_din),
    .flush  (tmr_wr_en),
    .step   (sync_step)
  );

  assign inc = use_sync ? sync_step : q4_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (tmr_wr_en) tmr_q <= tmr_wr_data;
      else if (inc)  tmr_q <= tmr_q + TMR_W'(1);
      if (!tmr_wr_en && inc && tmr_q == TMR_MAX) ovf_q <= 1'b1;
      else if (ovf_clr)                          ovf_q <= 1'b0;
    end
  end

  assign tmr_value = tmr_q;
  assign tmr_ovf   = ovf_q;
  assign wdt_tick  = (owner == OWN_WDT) ? (wdt_raw_tick & pre_last) : wdt_raw_tick;
endmodule

// File: rtl/tps_checker.sv
module tps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_wr_en,
  input logic [7:0] tmr_wr_data,
  input logic       ovf_clr,
  input logic       wdt_raw_tick,
  input logic       opt_pre_to_wdt,
  input logic [7:0] tmr_value,
  input logic       tmr_ovf,
  input logic       wdt_tick
);
  logic       wr_d;
  logic [7:0] val_d;
  logic       stepped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d  <= 1'b0;
      val_d <= 8'h00;
    end else begin
      wr_d  <= tmr_wr_en;
      val_d <= tmr_value;
    end
  end
  assign stepped = !wr_d && (tmr_value != val_d);

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n) tmr_wr_en |=> tmr_value == $past(tmr_wr_data)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) !tmr_wr_en |=> (tmr_value == $past(tmr_value) || tmr_value == $past(tmr_value) + 8'd1)); // R2
  AST_INC_SPACED: assert property (@(posedge clk) disable iff (!rst_n) stepped |=> !stepped); // R2
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (!tmr_wr_en && tmr_value == 8'hFF) |=> (tmr_value == 8'hFF || tmr_ovf)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tmr_ovf && !ovf_clr) |=> tmr_ovf); // R9
  AST_WDT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n) !opt_pre_to_wdt |-> wdt_tick == wdt_raw_tick); // R3
  AST_WDT_NO_SPUR: assert property (@(posedge clk) disable iff (!rst_n) !wdt_raw_tick |-> !wdt_tick); // R4
endmodule

bind tmr_presc_unit tps_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tmr_wr_en      (tmr_wr_en),
  .tmr_wr_data    (tmr_wr_data),
  .ovf_clr        (ovf_clr),
  .wdt_raw_tick   (wdt_raw_tick),
  .opt_pre_to_wdt (opt_pre_to_wdt),
  .tmr_value      (tmr_value),
  .tmr_ovf        (tmr_ovf),
  .wdt_tick       (wdt_tick)
);

// File: tb/tmr_presc_unit_bench.sv
module tmr_presc_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_pin = 1'b0;
  logic       tmr_wr_en = 1'b0;
  logic [7:0] tmr_wr_data = 8'h00;
  logic       ovf_clr = 1'b0;
  logic       wdt_raw_tick = 1'b0;
  logic       wdt_clr = 1'b0;
  logic       opt_src_pin = 1'b0;
  logic       opt_edge_fall = 1'b0;
  logic       opt_pre_to_wdt = 1'b0;
  logic [2:0] opt_ratio = 3'd0;
  logic [7:0] tmr_value;
  logic       tmr_ovf;
  logic       wdt_tick;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_presc_unit u_tmr_presc_unit (
    .clk(clk), .rst_n(rst_n), .ext_clk_pin(ext_clk_pin),
    .tmr_wr_en(tmr_wr_en), .tmr_wr_data(tmr_wr_data), .ovf_clr(ovf_clr),
    .wdt_raw_tick(wdt_raw_tick), .wdt_clr(wdt_clr),
    .opt_src_pin(opt_src_pin), .opt_edge_fall(opt_edge_fall),
    .opt_pre_to_wdt(opt_pre_to_wdt), .opt_ratio(opt_ratio),
    .tmr_value(tmr_value), .tmr_ovf(tmr_ovf), .wdt_tick(wdt_tick)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    tmr_wr_en = 1'b1; tmr_wr_data = v;
    tick(1);
    tmr_wr_en = 1'b0;
  endtask

  task automatic pulse(input int hi, input int lo);
    ext_clk_pin = 1'b1; tick(hi);
    ext_clk_pin = 1'b0; tick(lo);
  endtask

  task automatic raw_ticks(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      wdt_raw_tick = 1'b1; #1;
      if (wdt_tick) seen++;
      tick(1);
      wdt_raw_tick = 1'b0; tick(1);
    end
  endtask

  task automatic clr_wdt();
    wdt_clr = 1'b1; tick(1); wdt_clr = 1'b0;
  endtask

  task automatic set_opt(input logic src, input logic fall, input logic to_wdt, input logic [2:0] r);
    opt_src_pin = src; opt_edge_fall = fall; opt_pre_to_wdt = to_wdt; opt_ratio = r;
    tick(16);
  endtask

  task automatic t_reset();
    int seen;
    check("R1 timer after reset", tmr_value, 0);
    check("R1 ovf after reset", tmr_ovf, 0);
    opt_pre_to_wdt = 1'b1; opt_ratio = 3'd1;
    #1;
    raw_ticks(1, seen);
    check("R1 prescaler zero: first raw tick at 1:2", seen, 0);
    raw_ticks(1, seen);
    check("R1 prescaler zero: second raw tick at 1:2", seen, 1);
  endtask

  task automatic t_int_unscaled();
    set_opt(1'b0, 1'b0, 1'b1, 3'd5);
    wr_tmr(8'h10);
    tick(40);
    check("R2 instruction clock 1 per 4 clocks", tmr_value, 8'h1A);
    tick(4 * 7);
    check("R2 instruction clock continued", tmr_value, 8'h21);
  endtask

  task automatic t_int_prescaled();
    int seen;
    set_opt(1'b0, 1'b0, 1'b0, 3'd1);
    wr_tmr(8'h00);
    tick(160);
    check_rng("R3 timer 1:4 over 40 cycles", tmr_value, 9, 11);
    opt_ratio = 3'd0;
    wr_tmr(8'h00);
    tick(160);
    check_rng("R3 timer 1:2 over 40 cycles", tmr_value, 19, 21);
    opt_ratio = 3'd7;
    raw_ticks(3, seen);
    check("R3 watchdog unscaled while timer owns prescaler", seen, 3);
  endtask

  task automatic t_wdt_path();
    int seen;
    set_opt(1'b0, 1'b0, 1'b1, 3'd0);
    raw_ticks(5, seen);
    check("R4 watchdog ratio 1:1", seen, 5);
    opt_ratio = 3'd2;
    clr_wdt();
    raw_ticks(3, seen);
    check("R4 watchdog 1:4 first three", seen, 0);
    raw_ticks(1, seen);
    check("R4 watchdog 1:4 fourth", seen, 1);
    raw_ticks(3, seen);
    clr_wdt();
    raw_ticks(3, seen);
    check("R8 wdt_clr clears watchdog prescaler", seen, 0);
    raw_ticks(1, seen);
    check("R8 group completes after clear", seen, 1);
    raw_ticks(3, seen);
    wr_tmr(8'h55);
    raw_ticks(1, seen);
    check("R8 timer write leaves watchdog prescaler", seen, 1);
  endtask

  task automatic t_ext_edges();
    set_opt(1'b1, 1'b0, 1'b1, 3'd0);
    wr_tmr(8'h00);
    ext_clk_pin = 1'b1; tick(12);
    check("R5 rising edge counted", tmr_value, 1);
    ext_clk_pin = 1'b0; tick(12);
    check("R5 falling edge ignored in rising mode", tmr_value, 1);
    ext_clk_pin = 1'b1; tick(4);
    opt_edge_fall = 1'b1; tick(16);
    wr_tmr(8'h00);
    ext_clk_pin = 1'b0; tick(12);
    check("R5 falling edge counted in falling mode", tmr_value, 1);
    ext_clk_pin = 1'b1; tick(12);
    check("R5 rising edge ignored in falling mode", tmr_value, 1);
    ext_clk_pin = 1'b0; opt_edge_fall = 1'b0; tick(16);
    wr_tmr(8'h00);
    for (int i = 0; i < 10; i++) pulse(2, 2);
    tick(12);
    check("R5 ten 2-high 2-low pulses", tmr_value, 10);
  endtask

  task automatic t_ext_prescaled();
    set_opt(1'b1, 1'b0, 1'b0, 3'd0);
    wr_tmr(8'h00);
    for (int i = 0; i < 20; i++) pulse(1, 1);
    tick(16);
    check("R6 twenty narrow pulses at 1:2", tmr_value, 10);
  endtask

  task automatic t_pre_clear();
    set_opt(1'b1, 1'b0, 1'b0, 3'd1);
    wr_tmr(8'h00);
    pulse(2, 2); tick(16);
    wr_tmr(8'h40);
    pulse(2, 2); tick(16);
    check("R7 timer write cleared prescaler", tmr_value, 8'h40);
    pulse(2, 2); tick(16);
    check("R7 count resumes after second edge", tmr_value, 8'h41);
    wr_tmr(8'h00);
    pulse(2, 2); tick(4);
    clr_wdt();
    pulse(2, 2); tick(16);
    check("R8 wdt_clr ignored while timer owns prescaler", tmr_value, 1);
  endtask

  task automatic t_overflow();
    set_opt(1'b0, 1'b0, 1'b1, 3'd0);
    wr_tmr(8'hFE);
    tick(8);
    check("R9 wrap value", tmr_value, 0);
    check("R9 flag set on wrap", tmr_ovf, 1);
    tick(8);
    check("R9 flag sticky", tmr_ovf, 1);
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
    check("R9 flag cleared", tmr_ovf, 0);
    wr_tmr(8'hFF);
    check("R9 loading 0xFF leaves flag clear", tmr_ovf, 0);
  endtask

  task automatic t_latency();
    set_opt(1'b1, 1'b0, 1'b1, 3'd0);
    for (int a = 0; a < 4; a++) begin
      int k;
      wr_tmr(8'h00);
      tick(a);
      ext_clk_pin = 1'b1;
      k = 0;
      for (int j = 1; j <= 10; j++) begin
        tick(1);
        if (k == 0 && tmr_value != 8'h00) k = j;
      end
      check_rng("R10 pin edge to count latency", k, 2, 5);
      ext_clk_pin = 1'b0; tick(12);
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_int_unscaled();
    t_int_prescaled();
    t_wdt_path();
    t_ext_edges();
    t_ext_prescaled();
    t_pre_clear();
    t_overflow();
    t_latency();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule